// File: doc/BRIEF.md
# UART Buffering and DMA Ready Signaling

This block is the buffering core of a UART. It sits between the host write port and the bit-level serializer on the transmit side, and between the deserializer and the host on the receive side. Each direction has its own byte queue. A control register sets the depth of both queues: a single holding slot when buffering is off, and 16 or 64 slots when it is on. The same register sets a receive threshold and chooses one of two policies for the active-low DMA ready outputs.

In the single-transfer policy, the ready outputs report one character at a time. In the block-transfer policy, the transmit ready stays asserted while free space remains. The receive ready asserts when the threshold is reached and stays asserted until the receive queue drains, which gives it hysteresis. The interrupt requests follow the same policy. Software can flush either queue through self-clearing command bits. Overflow is recorded in sticky flags.

Top module: `uart_fifo_dma`

## Requirements
- R1: After reset the control value reads 0x00, both levels are 0, tx_rdy_n is 0, rx_rdy_n is 1, tx_irq is 1, rx_irq is 0, both overrun flags are 0 and both read-data outputs are 0x00.
- R2: A write on the control port stores bit 0 (buffer enable), bit 3 (policy: 0 single, 1 block), bit 5 (depth: 0 = 16, 1 = 64) and bits 7:6 (threshold code). cfg_q reads back bits 1, 2 and 4 as 0.
- R3: Each queue holds at most 1 character when bit 0 is 0, and otherwise 16 or 64 as bit 5 selects. Characters leave a queue in the order they entered, and each level output gives the current count.
- R4: A push that finds the queue at capacity, with no pop in the same cycle, is dropped and sets that direction's overrun flag. The flag stays set until that queue is flushed.
- R5: A pop of a non-empty queue shows the oldest character on the read-data output in the next cycle. A pop of an empty queue leaves the read data and the level unchanged.
- R6: Writing bit 1 as 1 flushes the receive queue and writing bit 2 as 1 flushes the transmit queue, including the overrun flag, at that clock edge. A flush wins over a push in the same cycle. A write that changes bit 0 or bit 5 flushes both queues.
- R7: In the single policy, or with buffering off, tx_rdy_n is 0 exactly when the transmit level is 0, and rx_rdy_n is 0 exactly when the receive level is at least 1.
- R8: The threshold codes 0, 1, 2 and 3 mean 1, 4, 8 and 14 characters at depth 16, and 1, 16, 32 and 56 characters at depth 64.
- R9: In the block policy, rx_rdy_n falls when the receive level reaches the threshold. It stays 0 until the receive level returns to 0.
- R10: In the block policy, tx_rdy_n is 0 while the transmit level is below capacity and 1 when the queue is full.
- R11: rx_irq is level >= threshold in the block policy and level != 0 otherwise. tx_irq is transmit level < threshold in the block policy and transmit level == 0 otherwise.
- R12: A push and a pop in the same cycle on a full queue are both accepted and the level is unchanged. On an empty queue the push is accepted and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_q | output | 8 | Stored control value |
| tx_push | input | 1 | Host writes a transmit character |
| tx_wdata | input | 8 | Transmit character |
| tx_pop | input | 1 | Serializer takes a transmit character |
| tx_rdata | output | 8 | Last character taken from the transmit queue |
| tx_level | output | 7 | Transmit queue count |
| tx_overrun | output | 1 | Sticky transmit overflow |
| rx_push | input | 1 | Deserializer delivers a character |
| rx_wdata | input | 8 | Received character |
| rx_pop | input | 1 | Host reads a received character |
| rx_rdata | output | 8 | Last character taken from the receive queue |
| rx_level | output | 7 | Receive queue count |
| rx_overrun | output | 1 | Sticky receive overflow |
| tx_rdy_n | output | 1 | Active-low transmit DMA ready |
| rx_rdy_n | output | 1 | Active-low receive DMA ready |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Three things can land on one clock edge: a push and a pop on the same queue, or a control write that flushes a queue while a push arrives. The bench drives a full queue and an empty queue with simultaneous push and pop. It also issues a flush write in the same cycle as a push. It judges each case against a queue-based reference model whose fixed priority is this: flush first, then pop, then push against the remaining space. A long mixed sequence with occasional mode and depth rewrites repeats these collisions under both ready policies.

// File: rtl/ufd_pkg.sv
package ufd_pkg;

   typedef struct packed {
      logic [1:0] thr_code;
      logic       deep;
      logic       blk_mode;
      logic       buf_en;
   } ufd_cfg_t;

   // threshold for code 0..3 at a given depth: 1, depth/4, depth/2, depth - depth/8
   function automatic int unsigned ufd_threshold(input logic [1:0] code,
                                                 input int unsigned depth);
      case (code)
         2'd0:    return 1;
         2'd1:    return depth / 4;
         2'd2:    return depth / 2;
         default: return depth - depth / 8;
      endcase
   endfunction

endpackage

// File: rtl/ufd_ctrl.sv
module ufd_ctrl
   import ufd_pkg::*;
#(
   parameter int unsigned MIN_DEPTH = 16,
   parameter int unsigned MAX_DEPTH = 64,
   parameter int unsigned CNT_W     = $clog2(MAX_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [7:0]       wdata,
   output ufd_cfg_t         cfg,
   output logic             flush_rx,
   output logic             flush_tx,
   output logic [CNT_W-1:0] cap,
   output logic [CNT_W-1:0] thr,
   output logic             blk_act
);

   ufd_cfg_t cfg_r;
   logic     geom_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_r <= '0;
      end else if (we) begin
         cfg_r.thr_code <= wdata[7:6];
         cfg_r.deep     <= wdata[5];
         cfg_r.blk_mode <= wdata[3];
         cfg_r.buf_en   <= wdata[0];
      end
   end

   // a change of enable or depth invalidates the stored pointers
   assign geom_chg = we && ((wdata[0] != cfg_r.buf_en) || (wdata[5] != cfg_r.deep));
   assign flush_rx = (we && wdata[1]) || geom_chg;
   assign flush_tx = (we && wdata[2]) || geom_chg;

   always_comb begin
      int unsigned depth;
      depth = cfg_r.deep ? MAX_DEPTH : MIN_DEPTH;
      if (cfg_r.buf_en) cap = CNT_W'(depth);
      else              cap = CNT_W'(1);
      thr = CNT_W'(ufd_threshold(cfg_r.thr_code, depth));
   end

   assign blk_act = cfg_r.buf_en && cfg_r.blk_mode;
   assign cfg     = cfg_r;

endmodule

// File: rtl/ufd_fifo.sv
module ufd_fifo #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MAX_DEPTH = 64,
   parameter int unsigned CNT_W     = $clog2(MAX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [CNT_W-1:0]  cap,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  count,
   output logic              overrun
);

   localparam int unsigned AW = $clog2(MAX_DEPTH);

   logic [DATA_W-1:0] mem [MAX_DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  cnt_r;
   logic              ovr_r;
   logic [DATA_W-1:0] rd_r;
   logic              pop_ok, push_ok;

   assign pop_ok  = !flush && pop && (cnt_r != '0);
   assign push_ok = !flush && push && ((cnt_r < cap) || pop_ok);

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_r  <= '0;
         ovr_r  <= 1'b0;
         rd_r   <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_r  <= '0;
         ovr_r  <= 1'b0;
      end else begin
         if (pop_ok) begin
            rd_r   <= mem[rd_ptr];
            rd_ptr <= rd_ptr + 1'b1;
         end
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (push && !push_ok) ovr_r <= 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt_r <= cnt_r + 1'b1;
            2'b01:   cnt_r <= cnt_r - 1'b1;
            default: cnt_r <= cnt_r;
         endcase
      end
   end

   assign rdata   = rd_r;
   assign count   = cnt_r;
   assign overrun = ovr_r;

endmodule

// File: rtl/ufd_ready.sv
module ufd_ready #(
   parameter int unsigned CNT_W = 7,
   parameter bit          IS_RX = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cap,
   input  logic [CNT_W-1:0] thr,
   input  logic             blk_act,
   output logic             rdy_n,
   output logic             irq
);

   logic any;
   assign any = (count != '0);

   generate
      if (IS_RX) begin : g_rx
         logic latch_q, latch_c;
         // hysteresis: armed at threshold, released only when empty
         assign latch_c = (count >= thr) || (latch_q && any);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) latch_q <= 1'b0;
            else        latch_q <= latch_c;
         end
         assign rdy_n = blk_act ? !latch_c : !any;
         assign irq   = blk_act ? (count >= thr) : any;
      end else begin : g_tx
         assign rdy_n = blk_act ? (count >= cap) : any;
         assign irq   = blk_act ? (count < thr) : !any;
      end
   endgenerate

endmodule

// File: rtl/uart_fifo_dma.sv
module uart_fifo_dma
   import ufd_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MIN_DEPTH = 16,
   parameter int unsigned MAX_DEPTH = 64,
   localparam int unsigned CNT_W    = $clog2(MAX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_q,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_rdata,
   output logic [CNT_W-1:0]  tx_level,
   output logic              tx_overrun,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_wdata,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_rdata,
   output logic [CNT_W-1:0]  rx_level,
   output logic              rx_overrun,
   output logic              tx_rdy_n,
   output logic              rx_rdy_n,
   output logic              tx_irq,
   output logic              rx_irq
);

   generate
      if (MIN_DEPTH < 8 || MIN_DEPTH > MAX_DEPTH)
         $error("uart_fifo_dma: MIN_DEPTH must be at least 8 and not above MAX_DEPTH");
      if ((MAX_DEPTH & (MAX_DEPTH - 1)) != 0)
         $error("uart_fifo_dma: MAX_DEPTH must be a power of two");
      if ((MIN_DEPTH % 8) != 0)
         $error("uart_fifo_dma: MIN_DEPTH must be a multiple of 8");
   endgenerate

   ufd_cfg_t         cfg;
   logic             flush_rx, flush_tx, blk_act;
   logic [CNT_W-1:0] cap, thr;

   ufd_ctrl #(.MIN_DEPTH(MIN_DEPTH), .MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wdata   (cfg_wdata),
      .cfg     (cfg),
      .flush_rx(flush_rx),
      .flush_tx(flush_tx),
      .cap     (cap),
      .thr     (thr),
      .blk_act (blk_act)
   );

   assign cfg_q = {cfg.thr_code, cfg.deep, 1'b0, cfg.blk_mode, 2'b00, cfg.buf_en};

   ufd_fifo #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush_tx), .cap(cap),
      .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
      .rdata(tx_rdata), .count(tx_level), .overrun(tx_overrun)
   );

   ufd_fifo #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush_rx), .cap(cap),
      .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
      .rdata(rx_rdata), .count(rx_level), .overrun(rx_overrun)
   );

   ufd_ready #(.CNT_W(CNT_W), .IS_RX(1'b0)) u_txrdy (
      .clk(clk), .rst_n(rst_n), .count(tx_level), .cap(cap), .thr(thr),
      .blk_act(blk_act), .rdy_n(tx_rdy_n), .irq(tx_irq)
   );

   ufd_ready #(.CNT_W(CNT_W), .IS_RX(1'b1)) u_rxrdy (
      .clk(clk), .rst_n(rst_n), .count(rx_level), .cap(cap), .thr(thr),
      .blk_act(blk_act), .rdy_n(rx_rdy_n), .irq(rx_irq)
   );

endmodule

// File: rtl/uart_fifo_dma_chk.sv
module uart_fifo_dma_chk #(
   parameter int unsigned CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [7:0]       cfg_wdata,
   input logic             rx_push,
   input logic             rx_pop,
   input logic [7:0]       rx_rdata,
   input logic [CNT_W-1:0] rx_level,
   input logic [CNT_W-1:0] tx_level,
   input logic             rx_overrun,
   input logic             rx_rdy_n,
   input logic             tx_rdy_n,
   input logic [CNT_W-1:0] cap,
   input logic             blk_act
);

   AST_TX_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= cap); // R3

   AST_RX_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= cap); // R3

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun && !cfg_we |=> rx_overrun); // R4

   AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop && (rx_level == '0) |=> $stable(rx_rdata)); // R5

   AST_FLUSH_RX: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_wdata[1] |=> (rx_level == '0) && !rx_overrun); // R6

   AST_SINGLE_RX: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_act |-> (rx_rdy_n == (rx_level == '0))); // R7

   AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      blk_act && !rx_rdy_n && (rx_level > 1) && !cfg_we |=> !rx_rdy_n); // R9

   AST_FULL_TX_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      blk_act && (tx_level == cap) |-> tx_rdy_n); // R10

   AST_EMPTY_PUSHPOP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push && rx_pop && (rx_level == '0) && (cap != '0) && !cfg_we |=> rx_level == 1); // R12

endmodule

bind uart_fifo_dma uart_fifo_dma_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
   .rx_push(rx_push), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
   .rx_level(rx_level), .tx_level(tx_level), .rx_overrun(rx_overrun),
   .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n), .cap(cap), .blk_act(blk_act)
);

// File: tb/tb_uart_fifo_dma.sv
module tb_uart_fifo_dma;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [7:0] tx_wdata = '0, rx_wdata = '0;
   logic [7:0] cfg_q, tx_rdata, rx_rdata;
   logic [6:0] tx_level, rx_level;
   logic       tx_overrun, rx_overrun, tx_rdy_n, rx_rdy_n, tx_irq, rx_irq;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_fifo_dma dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
      .tx_level(tx_level), .tx_overrun(tx_overrun),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
      .rx_level(rx_level), .rx_overrun(rx_overrun),
      .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n), .tx_irq(tx_irq), .rx_irq(rx_irq)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // ---------------- reference model ----------------
   logic [7:0] txq[$], rxq[$];
   bit   m_en, m_blk, m_deep, m_hold;
   bit   [1:0] m_code;
   bit   m_tovr, m_rovr;
   logic [7:0] m_trd, m_rrd;

   function automatic int m_cap();
      if (!m_en) return 1;
      return m_deep ? 64 : 16;
   endfunction

   function automatic int m_thr();
      case ({m_deep, m_code})
         3'b000: return 1;  3'b001: return 4;  3'b010: return 8;  3'b011: return 14;
         3'b100: return 1;  3'b101: return 16; 3'b110: return 32; default: return 56;
      endcase
   endfunction

   function automatic bit m_latch();
      return (rxq.size() >= m_thr()) || (m_hold && rxq.size() != 0);
   endfunction

   task automatic model_reset();
      txq.delete(); rxq.delete();
      m_en = 0; m_blk = 0; m_deep = 0; m_hold = 0; m_code = 0;
      m_tovr = 0; m_rovr = 0; m_trd = 0; m_rrd = 0;
   endtask

   task automatic model_step();
      bit fl_r, fl_t, geo, pok;
      int cp;
      cp   = m_cap();
      m_hold = m_latch();
      geo  = cfg_we && ((cfg_wdata[0] != m_en) || (cfg_wdata[5] != m_deep));
      fl_r = (cfg_we && cfg_wdata[1]) || geo;
      fl_t = (cfg_we && cfg_wdata[2]) || geo;
      if (fl_t) begin txq.delete(); m_tovr = 0; end
      else begin
         pok = tx_pop && txq.size() != 0;
         if (pok) m_trd = txq.pop_front();
         if (tx_push) begin
            if (txq.size() < cp) txq.push_back(tx_wdata); else m_tovr = 1;
         end
      end
      if (fl_r) begin rxq.delete(); m_rovr = 0; end
      else begin
         pok = rx_pop && rxq.size() != 0;
         if (pok) m_rrd = rxq.pop_front();
         if (rx_push) begin
            if (rxq.size() < cp) rxq.push_back(rx_wdata); else m_rovr = 1;
         end
      end
      if (cfg_we) begin
         m_code = cfg_wdata[7:6]; m_deep = cfg_wdata[5];
         m_blk = cfg_wdata[3];    m_en = cfg_wdata[0];
      end
   endtask

   // ---------------- checking ----------------
   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit bm;
      bm = m_en && m_blk;
      chk("R2", "cfg_q", cfg_q, {m_code, m_deep, 1'b0, m_blk, 2'b00, m_en});
      chk("R3", "tx_level", tx_level, txq.size());
      chk("R3", "rx_level", rx_level, rxq.size());
      chk("R4", "tx_overrun", tx_overrun, m_tovr);
      chk("R4", "rx_overrun", rx_overrun, m_rovr);
      chk("R5", "tx_rdata", tx_rdata, m_trd);
      chk("R5", "rx_rdata", rx_rdata, m_rrd);
      if (bm) begin
         chk("R10", "tx_rdy_n", tx_rdy_n, txq.size() >= m_cap());
         chk("R9", "rx_rdy_n", rx_rdy_n, !m_latch());
         chk("R11", "rx_irq", rx_irq, rxq.size() >= m_thr());
         chk("R11", "tx_irq", tx_irq, txq.size() < m_thr());
      end else begin
         chk("R7", "tx_rdy_n", tx_rdy_n, txq.size() != 0);
         chk("R7", "rx_rdy_n", rx_rdy_n, rxq.size() == 0);
         chk("R11", "rx_irq", rx_irq, rxq.size() != 0);
         chk("R11", "tx_irq", tx_irq, txq.size() == 0);
      end
   endtask

   // apply current inputs for one edge, then compare at the following falling edge
   task automatic cyc();
      model_step();
      @(negedge clk);
      compare_all();
      cfg_we = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
   endtask

   task automatic wcfg(input logic [7:0] v);
      cfg_we = 1; cfg_wdata = v; cyc();
   endtask

   task automatic rx_fill(input int n, input logic [7:0] base);
      for (int i = 0; i < n; i++) begin rx_push = 1; rx_wdata = base + 8'(i); cyc(); end
   endtask

   task automatic tx_fill(input int n, input logic [7:0] base);
      for (int i = 0; i < n; i++) begin tx_push = 1; tx_wdata = base + 8'(i); cyc(); end
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : stim
      int unsigned lf;
      logic [7:0] picks [10];
      picks = '{8'h00, 8'h01, 8'h21, 8'h09, 8'h49, 8'hA9, 8'hE9, 8'h2B, 8'h0D, 8'hC9};
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "cfg_q", cfg_q, 0);
      chk("R1", "levels", {tx_level, rx_level}, 0);
      chk("R1", "tx_rdy_n", tx_rdy_n, 0);
      chk("R1", "rx_rdy_n", rx_rdy_n, 1);
      chk("R1", "irqs", {tx_irq, rx_irq}, 2'b10);
      chk("R1", "overruns", {tx_overrun, rx_overrun}, 0);
      chk("R1", "rdata", {tx_rdata, rx_rdata}, 0);

      // buffering off: single slot
      rx_fill(1, 8'h11);
      chk("R7", "rx_rdy_n one char", rx_rdy_n, 0);
      rx_push = 1; rx_wdata = 8'h22; cyc();
      chk("R4", "overrun single slot", rx_overrun, 1);
      chk("R3", "single slot level", rx_level, 1);
      rx_pop = 1; cyc();
      chk("R5", "single slot data", rx_rdata, 8'h11);
      rx_pop = 1; cyc();
      chk("R5", "pop empty keeps data", rx_rdata, 8'h11);

      // depth 16 single policy, enable change flushes
      wcfg(8'h01);
      chk("R6", "enable change flushes overrun", rx_overrun, 0);
      tx_fill(17, 8'h40);
      chk("R3", "depth 16 cap", tx_level, 16);
      chk("R4", "tx overrun", tx_overrun, 1);
      for (int i = 0; i < 16; i++) begin
         tx_pop = 1; cyc();
         chk("R3", "order depth 16", tx_rdata, 8'h40 + i);
      end

      // depth 64, explicit receive flush keeps geometry
      wcfg(8'h21);
      rx_fill(65, 8'h80);
      chk("R3", "depth 64 cap", rx_level, 64);
      wcfg(8'h23);
      chk("R6", "rx flush level", rx_level, 0);
      chk("R2", "flush bits read zero", cfg_q, 8'h21);

      // block policy, depth 16, code 2 -> 8
      wcfg(8'h89);
      rx_fill(7, 8'h01);
      chk("R8", "below threshold 8", rx_rdy_n, 1);
      rx_fill(1, 8'h08);
      chk("R8", "at threshold 8", rx_rdy_n, 0);
      for (int i = 0; i < 7; i++) begin rx_pop = 1; cyc(); end
      chk("R9", "hysteresis at level 1", rx_rdy_n, 0);
      chk("R11", "rx_irq off below threshold", rx_irq, 0);
      rx_pop = 1; cyc();
      chk("R9", "release at empty", rx_rdy_n, 1);

      // block policy, depth 64, code 3 -> 56
      wcfg(8'hE9);
      rx_fill(55, 8'h00);
      chk("R8", "below threshold 56", rx_irq, 0);
      rx_fill(1, 8'h37);
      chk("R8", "at threshold 56", rx_irq, 1);
      tx_fill(63, 8'h00);
      chk("R10", "tx ready with space", tx_rdy_n, 0);
      tx_fill(1, 8'h3F);
      chk("R10", "tx full", tx_rdy_n, 1);
      tx_push = 1; tx_pop = 1; tx_wdata = 8'hAA; cyc();
      chk("R12", "full push+pop level", tx_level, 64);
      chk("R12", "full push+pop no overrun", tx_overrun, 0);
      wcfg(8'hED);
      chk("R6", "tx flush", tx_level, 0);
      tx_push = 1; tx_pop = 1; tx_wdata = 8'h5A; cyc();
      chk("R12", "empty push+pop level", tx_level, 1);
      chk("R12", "empty pop ignored", tx_rdata, 8'h00);
      cfg_we = 1; cfg_wdata = 8'hED; tx_push = 1; tx_wdata = 8'h66; cyc();
      chk("R6", "flush beats push", tx_level, 0);

      // mixed traffic with occasional reconfiguration
      lf = 32'h1234_5678;
      for (int i = 0; i < 4000; i++) begin
         lf = lf * 1103515245 + 12345;
         if (lf[30:25] == 0) begin cfg_we = 1; cfg_wdata = picks[lf[19:16] % 10]; end
         tx_push = lf[8]; tx_pop = lf[9] & lf[10];
         rx_push = lf[11] | lf[12]; rx_pop = lf[13];
         tx_wdata = lf[23:16]; rx_wdata = lf[31:24];
         cyc();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule